// File: doc/BRIEF.md
# IOTLB Invalidation Command Register

This block is a 64-bit control register that lets software start an invalidation of the translation cache inside an I/O address remapping unit, and then follow it to the end. Software writes the register through a byte-enabled port. The write sets a requested granularity and raises a request bit. The block then runs a short handshake sequence. When a capability strap says a write-buffer flush is required, it first requests that flush and waits for it to be acknowledged. It then presents an invalidation request, with the requested granularity, to the translation-cache logic and waits for a done pulse.

On completion the block does two things. It stores the granularity that the cache logic reports it actually applied, which can differ from the one requested. It also drops the request bit, so software polling the register sees the operation as finished.

Two kinds of request are rejected. A request made while another one is still in flight is ignored. A request made while a context-cache invalidation is pending starts nothing and raises a sticky error flag. The translation cache, the context-cache engine and the address register are outside the block and appear only as handshake pins.

Top module: `iotlb_inv_reg`

## Requirements
- R1: After reset, rd_data_o is all zeros and flush_req_o, inv_req_o and err_o are 0.
- R2: A write with wr_be_i[7]=1 and wr_data_i[63]=1, made while idle and with ctx_pend_i=0, starts a request. From the next cycle, rd_data_o[63] reads 1 until the request completes.
- R3: If wbf_cap_i=1 at the start, flush_req_o rises in the cycle after the start write and stays high until a cycle with flush_ack_i=1. inv_req_o rises in the following cycle.
- R4: If wbf_cap_i=0 at the start, inv_req_o rises in the cycle after the start write and flush_req_o stays 0.
- R5: inv_req_o stays high, with inv_gran_o equal to the requested granularity, until a cycle with inv_done_i=1. Two cycles after that edge, rd_data_o[63] is 0 and rd_data_o[58:57] holds the inv_gran_done_i value that was sampled with the done pulse.
- R6: While rd_data_o[63]=1, writes are ignored. A new request does not restart the sequence, and the requested granularity rd_data_o[5:4] does not change.
- R7: A write that sets the request bit while ctx_pend_i=1 starts no request. It sets the sticky error bit rd_data_o[62] and err_o, which stay 1 until reset.
- R8: A write with wr_be_i[0]=1, made while idle, loads the requested granularity rd_data_o[5:4] from wr_data_i[5:4]. A write with wr_be_i[7]=0 never starts a request.
- R9: flush_req_o and inv_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 8 | Byte enables of the write |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Current register value |
| wbf_cap_i | input | 1 | Strap: a write-buffer flush must come before an invalidation |
| ctx_pend_i | input | 1 | A context-cache invalidation is pending |
| flush_req_o | output | 1 | Write-buffer flush request |
| flush_ack_i | input | 1 | Write-buffer flush acknowledge |
| inv_req_o | output | 1 | Invalidation request to the translation cache |
| inv_gran_o | output | 2 | Requested granularity sent with inv_req_o |
| inv_done_i | input | 1 | Invalidation done pulse |
| inv_gran_done_i | input | 2 | Granularity actually applied, valid with inv_done_i |
| err_o | output | 1 | Sticky error: request made while a context-cache invalidation was pending |

## Verification
The hardest situations to reach are the ones where software writes into a request that is already in flight. These matter most during the flush wait and in the single completion cycle. The bench produces them by holding back the flush acknowledge and the done pulse for several cycles, and by issuing full-width writes inside those windows that try both to restart the request and to change the granularity. It also presents a done granularity that differs from the requested one, so that the reported field can be told apart from the requested field. A behavioural model follows every one of these writes cycle by cycle.

// File: rtl/iotlb_inv_pkg.sv
package iotlb_inv_pkg;
  localparam int unsigned REG_W   = 64;
  localparam int unsigned GRAN_W  = 2;
  localparam int unsigned BE_W    = REG_W / 8;
  localparam int unsigned REQ_BIT = REG_W - 1;
  localparam int unsigned ERR_BIT = REG_W - 2;
  localparam int unsigned ACT_LSB = 57;
  localparam int unsigned RQG_LSB = 4;
  localparam int unsigned RQG_BYTE = RQG_LSB / 8;
  localparam int unsigned TOP_BYTE = BE_W - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_INVAL = 2'd2,
    ST_CMPL  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/iotlb_wr_decode.sv
module iotlb_wr_decode
  import iotlb_inv_pkg::*;
#(
  parameter int unsigned GW  = GRAN_W,
  parameter int unsigned BEW = BE_W
) (
  input  logic          wr_en_i,
  input  logic [BEW-1:0] wr_be_i,
  input  logic          req_bit_i,
  input  logic [GW-1:0] gran_bits_i,
  input  logic          busy_i,
  input  logic          ctx_pend_i,
  output logic          start_o,
  output logic          err_set_o,
  output logic          gran_we_o,
  output logic [GW-1:0] gran_wd_o
);
  logic req_wr;

  // a request write needs the top byte lane and an idle sequencer
  assign req_wr    = wr_en_i & wr_be_i[TOP_BYTE] & req_bit_i & ~busy_i;
  assign start_o   = req_wr & ~ctx_pend_i;
  assign err_set_o = req_wr & ctx_pend_i;
  assign gran_we_o = wr_en_i & wr_be_i[RQG_BYTE] & ~busy_i;
  assign gran_wd_o = gran_bits_i;
endmodule

// File: rtl/iotlb_seq.sv
module iotlb_seq
  import iotlb_inv_pkg::*;
#(
  parameter int unsigned GW = GRAN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wbf_cap_i,
  input  logic          flush_ack_i,
  input  logic          inv_done_i,
  input  logic [GW-1:0] done_gran_i,
  output logic          busy_o,
  output logic          flush_req_o,
  output logic          inv_req_o,
  output logic          cmpl_o,
  output logic [GW-1:0] act_gran_o
);
  seq_st_e st_q, st_d;
  logic [GW-1:0] cap_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = wbf_cap_i ? ST_FLUSH : ST_INVAL;
      ST_FLUSH: if (flush_ack_i) st_d = ST_INVAL;
      ST_INVAL: if (inv_done_i) st_d = ST_CMPL;
      ST_CMPL:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cap_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_INVAL && inv_done_i) cap_q <= done_gran_i;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign flush_req_o = (st_q == ST_FLUSH);
  assign inv_req_o   = (st_q == ST_INVAL);
  assign cmpl_o      = (st_q == ST_CMPL);
  assign act_gran_o  = cap_q;
endmodule

// File: rtl/iotlb_fields.sv
module iotlb_fields
  import iotlb_inv_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned GW = GRAN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          err_set_i,
  input  logic          gran_we_i,
  input  logic [GW-1:0] gran_wd_i,
  input  logic          cmpl_i,
  input  logic [GW-1:0] act_gran_i,
  output logic [RW-1:0] rd_data_o,
  output logic [GW-1:0] req_gran_o,
  output logic          err_o
);
  logic          req_q, err_q;
  logic [GW-1:0] act_q, rqg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      err_q <= 1'b0;
      act_q <= '0;
      rqg_q <= '0;
    end else begin
      if (start_i)        req_q <= 1'b1;
      else if (cmpl_i)    req_q <= 1'b0;
      if (err_set_i)      err_q <= 1'b1;
      if (cmpl_i)         act_q <= act_gran_i;
      if (gran_we_i)      rqg_q <= gran_wd_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[REQ_BIT] = req_q;
    rd_data_o[ERR_BIT] = err_q;
    rd_data_o[ACT_LSB +: GW] = act_q;
    rd_data_o[RQG_LSB +: GW] = rqg_q;
  end

  assign req_gran_o = rqg_q;
  assign err_o      = err_q;
endmodule

// File: rtl/iotlb_inv_reg.sv
module iotlb_inv_reg
  import iotlb_inv_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned GW = GRAN_W,
  localparam int unsigned BEW = RW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [BEW-1:0] wr_be_i,
  input  logic [RW-1:0] wr_data_i,
  output logic [RW-1:0] rd_data_o,
  input  logic          wbf_cap_i,
  input  logic          ctx_pend_i,
  output logic          flush_req_o,
  input  logic          flush_ack_i,
  output logic          inv_req_o,
  output logic [GW-1:0] inv_gran_o,
  input  logic          inv_done_i,
  input  logic [GW-1:0] inv_gran_done_i,
  output logic          err_o
);
  logic          start, err_set, gran_we, busy, cmpl;
  logic [GW-1:0] gran_wd, act_gran;

  iotlb_wr_decode #(.GW(GW), .BEW(BEW)) i_dec (
    .wr_en_i     (wr_en_i),
    .wr_be_i     (wr_be_i),
    .req_bit_i   (wr_data_i[RW-1]),
    .gran_bits_i (wr_data_i[RQG_LSB +: GW]),
    .busy_i      (busy),
    .ctx_pend_i  (ctx_pend_i),
    .start_o     (start),
    .err_set_o   (err_set),
    .gran_we_o   (gran_we),
    .gran_wd_o   (gran_wd)
  );

  iotlb_seq #(.GW(GW)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .wbf_cap_i   (wbf_cap_i),
    .flush_ack_i (flush_ack_i),
    .inv_done_i  (inv_done_i),
    .done_gran_i (inv_gran_done_i),
    .busy_o      (busy),
    .flush_req_o (flush_req_o),
    .inv_req_o   (inv_req_o),
    .cmpl_o      (cmpl),
    .act_gran_o  (act_gran)
  );

  iotlb_fields #(.RW(RW), .GW(GW)) i_fld (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .err_set_i  (err_set),
    .gran_we_i  (gran_we),
    .gran_wd_i  (gran_wd),
    .cmpl_i     (cmpl),
    .act_gran_i (act_gran),
    .rd_data_o  (rd_data_o),
    .req_gran_o (inv_gran_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/iotlb_inv_chk.sv
module iotlb_inv_chk #(
  parameter int unsigned RW = 64,
  parameter int unsigned GW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [RW-1:0] rd_data_o,
  input logic          flush_req_o,
  input logic          flush_ack_i,
  input logic          inv_req_o,
  input logic [GW-1:0] inv_gran_o,
  input logic          inv_done_i,
  input logic          err_o
);
  // R9
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flush_req_o && inv_req_o));
  // R3
  flush_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o && !flush_ack_i |=> flush_req_o);
  // R3
  flush_then_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o && flush_ack_i |=> inv_req_o);
  // R5
  inv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o && !inv_done_i |=> inv_req_o && $stable(inv_gran_o));
  // R2
  req_bit_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o || inv_req_o) |-> rd_data_o[RW-1]);
  // R6
  gran_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[RW-1] |=> $stable(rd_data_o[5:4]));
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && rd_data_o[RW-2]);
endmodule

bind iotlb_inv_reg iotlb_inv_chk #(.RW(RW), .GW(GW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_data_o   (rd_data_o),
  .flush_req_o (flush_req_o),
  .flush_ack_i (flush_ack_i),
  .inv_req_o   (inv_req_o),
  .inv_gran_o  (inv_gran_o),
  .inv_done_i  (inv_done_i),
  .err_o       (err_o)
);

// File: tb/test_iotlb_inv_reg.sv
`timescale 1ns/1ps
module test_iotlb_inv_reg;
  localparam int PER = 10;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_be = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        cap = 0, ctx = 0, fack = 0, done = 0;
  logic [1:0]  dgran = '0;
  logic        freq, ireq, err;
  logic [1:0]  igran;

  int n_cmp = 0, n_bad = 0;

  always #(PER/2) clk = ~clk;

  iotlb_inv_reg i_iotlb_inv_reg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_be_i(wr_be),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .wbf_cap_i(cap),
    .ctx_pend_i(ctx), .flush_req_o(freq), .flush_ack_i(fack),
    .inv_req_o(ireq), .inv_gran_o(igran), .inv_done_i(done),
    .inv_gran_done_i(dgran), .err_o(err)
  );

  // behavioural reference: 0 idle, 1 flushing, 2 invalidating, 3 completing
  int         m_st;
  logic       m_req, m_err;
  logic [1:0] m_gran, m_act, m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_req <= 0; m_err <= 0; m_gran <= 0; m_act <= 0; m_hold <= 0;
    end else begin
      if (wr_en && m_st == 0 && wr_be[0]) m_gran <= wr_data[5:4];
      if (m_st == 0 && wr_en && wr_be[7] && wr_data[63]) begin
        if (ctx) m_err <= 1;
        else begin m_req <= 1; m_st <= cap ? 1 : 2; end
      end
      if (m_st == 1 && fack) m_st <= 2;
      if (m_st == 2 && done) begin m_hold <= dgran; m_st <= 3; end
      if (m_st == 3) begin m_act <= m_hold; m_req <= 0; m_st <= 0; end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(PER/4);
    if (rst_n) begin
      logic [63:0] e;
      e = '0; e[63] = m_req; e[62] = m_err; e[58:57] = m_act; e[5:4] = m_gran;
      chk("R2 request bit", {63'd0, rd_data[63]}, {63'd0, e[63]});
      chk("R5 register fields", rd_data, e);
      chk("R3 flush_req", {63'd0, freq}, {63'd0, m_st == 1});
      chk("R4 inv_req", {63'd0, ireq}, {63'd0, m_st == 2});
      if (m_st == 2) chk("R5 inv_gran", {62'd0, igran}, {62'd0, m_gran});
      chk("R7 err_o", {63'd0, err}, {63'd0, m_err});
      chk("R9 exclusive requests", {63'd0, freq & ireq}, 64'd0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] be, input logic [63:0] d);
    @(negedge clk); wr_en = 1; wr_be = be; wr_data = d;
    @(negedge clk); wr_en = 0; wr_be = '0; wr_data = '0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); fack = 1; @(negedge clk); fack = 0;
  endtask

  task automatic pulse_done(input logic [1:0] g);
    @(negedge clk); done = 1; dgran = g; @(negedge clk); done = 0; dgran = '0;
  endtask

  function automatic logic [63:0] req_word(input logic [1:0] g);
    return {1'b1, 57'd0, g, 4'd0};
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(PER * 100000);
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    report();
  end

  initial begin
    cyc(2);
    // R1 reset state
    chk("R1 rd_data reset", rd_data, 64'd0);
    chk("R1 outputs reset", {60'd0, freq, ireq, err, 1'b0}, 64'd0);
    rst_n = 1;
    cyc(2);

    // R4 no flush strap, done reports a coarser granularity than requested
    cap = 0;
    wr(8'hFF, req_word(2'd2));
    chk("R2 request bit set", {63'd0, rd_data[63]}, 64'd1);
    cyc(3);
    pulse_done(2'd1);
    cyc(2);
    chk("R5 actual granularity", {62'd0, rd_data[58:57]}, 64'd1);

    // R3 flush strap, long ack wait, writes into busy window
    cap = 1;
    wr(8'hFF, req_word(2'd3));
    cyc(2);
    wr(8'hFF, req_word(2'd0));   // R6 ignored in flush wait
    chk("R6 gran unchanged while busy", {62'd0, rd_data[5:4]}, 64'd3);
    pulse_ack();
    cyc(1);
    wr(8'hFF, req_word(2'd1));   // R6 ignored during invalidation
    pulse_done(2'd3);
    chk("R6 completing cycle", {63'd0, rd_data[63]}, 64'd1);
    cyc(2);
    chk("R6 back to idle", {63'd0, rd_data[63]}, 64'd0);
    chk("R6 gran held", {62'd0, rd_data[5:4]}, 64'd3);

    // R8 low byte only: gran changes, no start
    wr(8'h01, {1'b1, 57'd0, 2'd1, 4'd0});
    cyc(1);
    chk("R8 no start without top byte", {63'd0, rd_data[63]}, 64'd0);
    chk("R8 gran written", {62'd0, rd_data[5:4]}, 64'd1);
    // R8 top byte only with request bit 0
    wr(8'h80, 64'd0);
    cyc(1);
    chk("R8 no start with request bit clear", {63'd0, rd_data[63]}, 64'd0);

    // R7 context-cache pending
    ctx = 1;
    wr(8'hFF, req_word(2'd2));
    ctx = 0;
    cyc(1);
    chk("R7 no start", {63'd0, rd_data[63]}, 64'd0);
    chk("R7 error bit", {63'd0, rd_data[62]}, 64'd1);
    cap = 0;
    wr(8'hFF, req_word(2'd0));
    pulse_done(2'd2);
    cyc(3);
    chk("R7 error stays", {63'd0, err}, 64'd1);
    chk("R5 actual granularity 2", {62'd0, rd_data[58:57]}, 64'd2);

    // stray handshakes while idle have no effect
    pulse_done(2'd0);
    pulse_ack();
    cyc(2);
    chk("R5 idle done ignored", {62'd0, rd_data[58:57]}, 64'd2);
    report();
  end
endmodule